// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block is the timekeeping core of a real-time clock. It counts seconds, minutes, hours, day of week, date, month, year and century in packed BCD, 24-hour format. A one-second enable pulse from an oscillator prescaler drives the count. The core holds two copies of the time. One is the live counter set. The other is a view set that the host reads and writes through a small synchronous register bus.

Two bits in the control register govern the view. The freeze bit stops the view at the count it held when the bit was set, so a multi-byte read stays coherent while the live counters keep running. The load bit stops the view from following the counters and opens the time registers to host writes. While it is set, incoming ticks are thrown away. Clearing it copies the view into the live counters, and counting resumes from that value. A stop bit in the seconds register halts the count altogether, and the clock comes out of reset stopped.

Top module: `rtc_core`

## Requirements
- R1: After reset the seconds register reads 0x80 (stop bit set, 00 seconds). The control register reads 0x00. Minutes and hours read 0x00, day of week, date and month read 0x01, and year reads 0x00.
- R2: The register addresses are 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month and 7 year. Each holds packed BCD with the tens digit in the upper nibble. Bits beyond each field's width (seconds 7, minutes 7, hours 6, day 3, date 6, month 5, year 8, century 6 bits) are discarded on write and read as 0. The exceptions are the stop bit (seconds bit 7) and the control bits.
- R3: Seconds bit 7 is the stop bit. While it is 1, ticks do not advance the count. Writing 0 lets the count run. A write to it takes effect whatever the state of the load bit.
- R4: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into both date and day of week. Day of week wraps from 07 to 01.
- R5: Date wraps to 01 after the last day of the month: 30 for April, June, September and November, 31 for the other long months, and for February 29 when the year is a multiple of 4, else 28. The wrap carries into the month.
- R6: Month wraps from 12 to 01 and carries into the year. Year wraps from 99 to 00 and carries into the century, which occupies control bits 5:0 and wraps from 39 to 00.
- R7: Control bit 6 is the freeze bit. While it is 1 (and the load bit is 0), the view holds the count captured when the bit was set, while the live counters advance. Once it is 0, the view shows the live count from the next cycle on.
- R8: Control bit 7 is the load bit. While it is 1, time and century writes land in the view and ticks are discarded. Clearing it copies the view, including a century written in that same control write, into the live counters. A tick in the clearing cycle is discarded too.
- R9: While the load bit is 0, writes to the time registers (other than the stop bit) have no effect on the time. A control write that leaves the load bit 0 does not change the century.
- R10: When the freeze and load bits are both set, the load behaviour applies. If the load bit is cleared while the freeze bit stays 1, the live counters take the loaded value and the view stays frozen at it.
- R11: Read data is registered. It shows the addressed register one cycle after a read strobe and holds its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |

## Verification
The load transfer and a tick can meet in one cycle: the bench clears the load bit in the same clock in which it raises the tick pulse. The seconds register must then read back exactly the loaded value, and exactly one count higher after one further tick, which shows that the transfer won and the tick was dropped. A second collision is a tick arriving while the freeze bit holds the view. The bench judges it by seeing the frozen value unchanged and, after release, a value that includes every tick received during the freeze.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int REG_AW = 3;
  localparam int BYTE_W = 8;

  localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] A_SEC  = 3'd1;
  localparam logic [REG_AW-1:0] A_MIN  = 3'd2;
  localparam logic [REG_AW-1:0] A_HR   = 3'd3;
  localparam logic [REG_AW-1:0] A_DOW  = 3'd4;
  localparam logic [REG_AW-1:0] A_DATE = 3'd5;
  localparam logic [REG_AW-1:0] A_MON  = 3'd6;
  localparam logic [REG_AW-1:0] A_YR   = 3'd7;

  typedef struct packed {
    logic [BYTE_W-1:0] cent;
    logic [BYTE_W-1:0] yr;
    logic [BYTE_W-1:0] mon;
    logic [BYTE_W-1:0] date;
    logic [BYTE_W-1:0] dow;
    logic [BYTE_W-1:0] hr;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_AT_RESET = '{
    cent: 8'h00, yr: 8'h00, mon: 8'h01, date: 8'h01,
    dow: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00
  };

  // Add one to a two-digit packed BCD value.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // A two-digit BCD year is a multiple of 4 when an even tens digit pairs
  // with 0/4/8, or an odd tens digit pairs with 2/6.
  function automatic logic bcd_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    else      return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] m,
                                                input logic [7:0] y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
#(
  parameter logic [7:0] CENT_LAST = 8'h39
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick_i,
  input  logic      stop_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t cnt_o
);

  rtc_time_t cnt, nxt;
  logic      adv;

  assign adv = tick_i & ~stop_i;

  always_comb begin
    nxt = cnt;
    if (adv) begin
      if (cnt.sec == 8'h59) begin
        nxt.sec = 8'h00;
        if (cnt.min == 8'h59) begin
          nxt.min = 8'h00;
          if (cnt.hr == 8'h23) begin
            nxt.hr  = 8'h00;
            nxt.dow = (cnt.dow == 8'h07) ? 8'h01 : bcd_inc(cnt.dow);
            if (cnt.date == month_last_day(cnt.mon, cnt.yr)) begin
              nxt.date = 8'h01;
              if (cnt.mon == 8'h12) begin
                nxt.mon = 8'h01;
                if (cnt.yr == 8'h99) begin
                  nxt.yr   = 8'h00;
                  nxt.cent = (cnt.cent == CENT_LAST) ? 8'h00 : bcd_inc(cnt.cent);
                end else begin
                  nxt.yr = bcd_inc(cnt.yr);
                end
              end else begin
                nxt.mon = bcd_inc(cnt.mon);
              end
            end else begin
              nxt.date = bcd_inc(cnt.date);
            end
          end else begin
            nxt.hr = bcd_inc(cnt.hr);
          end
        end else begin
          nxt.min = bcd_inc(cnt.min);
        end
      end else begin
        nxt.sec = bcd_inc(cnt.sec);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt <= TIME_AT_RESET;
    else if (load_i) cnt <= load_val_i;
    else             cnt <= nxt;
  end

  assign cnt_o = cnt;

  logic at_midnight_edge;
  assign at_midnight_edge = (cnt.sec == 8'h59) && (cnt.min == 8'h59) && (cnt.hr == 8'h23);

  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !stop_i && !load_i && cnt.sec == 8'h59)
      |=> (cnt.sec == 8'h00 && cnt.min != $past(cnt.min)));

  assert_dow_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !stop_i && !load_i && at_midnight_edge && cnt.dow == 8'h07)
      |=> (cnt.dow == 8'h01));

  assert_leap_feb_R5: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !stop_i && !load_i && at_midnight_edge && cnt.mon == 8'h02
     && cnt.date == 8'h28 && bcd_leap(cnt.yr))
      |=> (cnt.date == 8'h29 && cnt.mon == 8'h02));

  assert_year_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !stop_i && !load_i && at_midnight_edge && cnt.mon == 8'h12
     && cnt.date == 8'h31 && cnt.yr == 8'h99)
      |=> (cnt.yr == 8'h00 && cnt.mon == 8'h01));

  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !load_i) |=> $stable(cnt));

endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  input  rtc_time_t         live_i,
  output logic [BYTE_W-1:0] rdata,
  output logic              osc_stop_o,
  output logic              load_bit_o,
  output logic              xfer_o,
  output rtc_time_t         xfer_val_o
);

  rtc_time_t view;
  logic      load_bit, freeze_bit, osc_stop;
  logic      ctrl_wr;

  assign ctrl_wr = wr && (addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      view       <= TIME_AT_RESET;
      load_bit   <= 1'b0;
      freeze_bit <= 1'b0;
      osc_stop   <= 1'b1;
    end else begin
      if (!load_bit && !freeze_bit) view <= live_i;
      if (ctrl_wr) begin
        load_bit   <= wdata[7];
        freeze_bit <= wdata[6];
        if (load_bit || wdata[7]) view.cent <= {2'b00, wdata[5:0]};
      end
      if (wr && addr == A_SEC) osc_stop <= wdata[7];
      if (wr && load_bit) begin
        case (addr)
          A_SEC:   view.sec  <= {1'b0, wdata[6:0]};
          A_MIN:   view.min  <= {1'b0, wdata[6:0]};
          A_HR:    view.hr   <= {2'b00, wdata[5:0]};
          A_DOW:   view.dow  <= {5'b00000, wdata[2:0]};
          A_DATE:  view.date <= {2'b00, wdata[5:0]};
          A_MON:   view.mon  <= {3'b000, wdata[4:0]};
          A_YR:    view.yr   <= wdata;
          default: ;
        endcase
      end
    end
  end

  // Transfer fires on the control write that clears a set load bit.
  always_comb begin
    xfer_val_o      = view;
    xfer_val_o.cent = {2'b00, wdata[5:0]};
  end
  assign xfer_o     = ctrl_wr && load_bit && !wdata[7];
  assign osc_stop_o = osc_stop;
  assign load_bit_o = load_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      case (addr)
        A_CTRL:  rdata <= {load_bit, freeze_bit, view.cent[5:0]};
        A_SEC:   rdata <= {osc_stop, view.sec[6:0]};
        A_MIN:   rdata <= {1'b0, view.min[6:0]};
        A_HR:    rdata <= {2'b00, view.hr[5:0]};
        A_DOW:   rdata <= {5'b00000, view.dow[2:0]};
        A_DATE:  rdata <= {2'b00, view.date[5:0]};
        A_MON:   rdata <= {3'b000, view.mon[4:0]};
        default: rdata <= view.yr;
      endcase
    end
  end

  assert_view_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (freeze_bit && !load_bit && !ctrl_wr) |=> $stable(view));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));

  assert_xfer_needs_load_R8: assert property (@(posedge clk) disable iff (rst)
    xfer_o |=> !load_bit);

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter logic [7:0] CENT_LAST = 8'h39
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [REG_AW-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [BYTE_W-1:0] rdata
);

  rtc_time_t live, xfer_val;
  logic      osc_stop, load_bit, xfer;

  rtc_host_regs u_host (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wdata      (wdata),
    .wr         (wr),
    .rd         (rd),
    .live_i     (live),
    .rdata      (rdata),
    .osc_stop_o (osc_stop),
    .load_bit_o (load_bit),
    .xfer_o     (xfer),
    .xfer_val_o (xfer_val)
  );

  rtc_counter #(.CENT_LAST(CENT_LAST)) u_count (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .stop_i     (osc_stop | load_bit),
    .load_i     (xfer),
    .load_val_i (xfer_val),
    .cnt_o      (live)
  );

  assert_xfer_lands_R8: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (live == $past(xfer_val)));

  assert_ticks_dropped_R8: assert property (@(posedge clk) disable iff (rst)
    (load_bit && !xfer) |=> $stable(live));

endmodule

// File: tb/rtc_core_tb.sv
module rtc_core_tb;
  import rtc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];
  logic  rd_seen = 1'b0;

  always #5 clk = ~clk;

  rtc_core u_dut (
    .clk(clk), .rst(rst), .tick(tick), .addr(addr),
    .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata)
  );

  always @(posedge clk) rd_seen <= rd;

  // Monitor: compares each returned byte against the queued expectation.
  always @(negedge clk) begin
    if (rd_seen && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: got %02h expected %02h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input bit with_tick);
    addr = a; wdata = d; wr = 1'b1; tick = with_tick;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic load_time(input logic [7:0] c, input logic [7:0] y, input logic [7:0] mo,
                           input logic [7:0] dt, input logic [7:0] dw, input logic [7:0] h,
                           input logic [7:0] mi, input logic [7:0] s);
    wr_reg(A_CTRL, 8'h80 | c, 1'b0);
    wr_reg(A_YR, y, 1'b0);
    wr_reg(A_MON, mo, 1'b0);
    wr_reg(A_DATE, dt, 1'b0);
    wr_reg(A_DOW, dw, 1'b0);
    wr_reg(A_HR, h, 1'b0);
    wr_reg(A_MIN, mi, 1'b0);
    wr_reg(A_SEC, s, 1'b0);
    wr_reg(A_CTRL, c, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd_chk(A_SEC, 8'h80, "R1 sec");
    rd_chk(A_CTRL, 8'h00, "R1 ctrl");
    rd_chk(A_MIN, 8'h00, "R1 min");
    rd_chk(A_HR, 8'h00, "R1 hr");
    rd_chk(A_DOW, 8'h01, "R1 dow");
    rd_chk(A_DATE, 8'h01, "R1 date");
    rd_chk(A_MON, 8'h01, "R1 mon");
    rd_chk(A_YR, 8'h00, "R1 yr");

    // R3 stopped clock ignores ticks, then runs
    ticks(3);
    rd_chk(A_SEC, 8'h80, "R3 stopped");
    wr_reg(A_SEC, 8'h00, 1'b0);
    ticks(5);
    rd_chk(A_SEC, 8'h05, "R3 running");

    // R11 read data holds without a strobe
    ticks(1);
    repeat (2) @(negedge clk);
    checks++;
    if (rdata !== 8'h05) begin
      errors++;
      $display("FAIL R11 hold: got %02h expected %02h", rdata, 8'h05);
    end
    rd_chk(A_SEC, 8'h06, "R11 refresh");

    // R9 time writes ignored with load bit clear
    wr_reg(A_MIN, 8'h33, 1'b0);
    rd_chk(A_MIN, 8'h00, "R9 min");
    wr_reg(A_SEC, 8'h25, 1'b0);
    rd_chk(A_SEC, 8'h06, "R9 sec");
    wr_reg(A_CTRL, 8'h15, 1'b0);
    rd_chk(A_CTRL, 8'h00, "R9 century");

    // R8 and R2: load, field masking, ticks discarded
    wr_reg(A_CTRL, 8'h99, 1'b0);
    wr_reg(A_SEC, 8'h58, 1'b0);
    wr_reg(A_MIN, 8'h59, 1'b0);
    wr_reg(A_HR, 8'h23, 1'b0);
    wr_reg(A_DOW, 8'hFF, 1'b0);
    wr_reg(A_DATE, 8'h28, 1'b0);
    wr_reg(A_MON, 8'hE2, 1'b0);
    wr_reg(A_YR, 8'h99, 1'b0);
    ticks(2);
    rd_chk(A_SEC, 8'h58, "R8 view sec");
    rd_chk(A_DOW, 8'h07, "R2 dow mask");
    rd_chk(A_MON, 8'h02, "R2 mon mask");
    rd_chk(A_CTRL, 8'h99, "R8 ctrl");
    wr_reg(A_CTRL, 8'h19, 1'b1);  // clear load bit with a tick in the same cycle
    rd_chk(A_SEC, 8'h58, "R8 load beats tick");
    rd_chk(A_CTRL, 8'h19, "R8 century loaded");
    ticks(1);
    rd_chk(A_SEC, 8'h59, "R8 resumes");
    ticks(1);
    rd_chk(A_SEC, 8'h00, "R4 sec wrap");
    rd_chk(A_MIN, 8'h00, "R4 min wrap");
    rd_chk(A_HR, 8'h00, "R4 hr wrap");
    rd_chk(A_DOW, 8'h01, "R4 dow wrap");
    rd_chk(A_DATE, 8'h01, "R5 feb 28 non-leap");
    rd_chk(A_MON, 8'h03, "R5 month carry");
    rd_chk(A_YR, 8'h99, "R5 year kept");

    // R6 year and century wrap
    load_time(8'h39, 8'h99, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59);
    ticks(1);
    rd_chk(A_YR, 8'h00, "R6 yr wrap");
    rd_chk(A_MON, 8'h01, "R6 mon wrap");
    rd_chk(A_DATE, 8'h01, "R6 date wrap");
    rd_chk(A_DOW, 8'h04, "R4 dow inc");
    rd_chk(A_CTRL, 8'h00, "R6 century wrap");

    // R5 month lengths
    load_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    rd_chk(A_DATE, 8'h29, "R5 leap feb 29");
    rd_chk(A_MON, 8'h02, "R5 leap feb month");
    load_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    rd_chk(A_DATE, 8'h01, "R5 leap feb end");
    rd_chk(A_MON, 8'h03, "R5 leap to mar");
    load_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    rd_chk(A_DATE, 8'h01, "R5 apr 30");
    rd_chk(A_MON, 8'h05, "R5 to may");
    load_time(8'h20, 8'h23, 8'h05, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    rd_chk(A_DATE, 8'h31, "R5 may 31");

    // R7 freeze while live count runs
    load_time(8'h20, 8'h23, 8'h05, 8'h10, 8'h02, 8'h10, 8'h20, 8'h10);
    wr_reg(A_CTRL, 8'h40, 1'b0);
    ticks(3);
    rd_chk(A_SEC, 8'h10, "R7 frozen");
    rd_chk(A_CTRL, 8'h60, "R7 ctrl");
    wr_reg(A_CTRL, 8'h00, 1'b0);
    rd_chk(A_SEC, 8'h13, "R7 released");
    rd_chk(A_CTRL, 8'h20, "R7 century intact");

    // R10 both bits set
    wr_reg(A_CTRL, 8'hE0, 1'b0);
    wr_reg(A_SEC, 8'h45, 1'b0);
    ticks(2);
    wr_reg(A_CTRL, 8'h60, 1'b0);
    rd_chk(A_SEC, 8'h45, "R10 loaded view");
    ticks(2);
    rd_chk(A_SEC, 8'h45, "R10 still frozen");
    wr_reg(A_CTRL, 8'h20, 1'b0);
    rd_chk(A_SEC, 8'h47, "R10 live from load");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule